// File: doc/BRIEF.md
# Block Scan Timing Generator

This block drives the scan side of a display whose rows are grouped into row blocks and whose columns are grouped into column blocks. From a single base clock it produces a start pulse that opens each frame, a start pulse that opens each row block, and two complementary shift-clock pairs, one stepping through row blocks and one stepping through column blocks. It also exposes the current row-block and column-block numbers, so the pixel data path can load the matching block without keeping its own count.

A column block lasts a fixed number of base clocks. The row block in use stays selected while every column block is visited once. Each high phase and each low phase of a shift-clock pair strobes one block, so a pair toggles once per block and its period covers two blocks. Every phase change of a pair starts with a short dead window, during which both members are low. The start pulses stay high for exactly one block of the level they open, so the row start has a duty of one row block per frame and the column start a duty of one column block per row block. The block counts, the column-block length and the dead window are parameters, so a reduced geometry can run in simulation. The block has no data stream of its own: every pin is a plain control level, and there is no back-pressure.

Top module: `scan_timing_gen`

## Requirements
- R1: While `rst_n` is low, all six timing outputs are low and both block indices are 0.
- R2: On the first cycle after reset is released, `row_start` and `col_start` are both high, with `row_idx` = 0 and `col_idx` = 0.
- R3: `col_idx` holds for COL_TICKS cycles, then advances by one. After COL_BLOCKS-1 it returns to 0.
- R4: `row_idx` advances by one in the cycle where `col_idx` returns from COL_BLOCKS-1 to 0. After ROW_BLOCKS-1 it returns to 0, which starts a new frame.
- R5: `col_start` is high exactly while `col_idx` = 0. It is therefore high for one column block in every row block.
- R6: `row_start` is high exactly while `row_idx` = 0. It is therefore high for one row block in every frame.
- R7: In the first DEAD_TICKS cycles of every column block, `col_clk` and `col_clk_n` are both low. For the rest of the block, `col_clk` is high when `col_idx` is even and `col_clk_n` is high when `col_idx` is odd.
- R8: In the first DEAD_TICKS cycles of every row block, `row_clk` and `row_clk_n` are both low. For the rest of the block, `row_clk` is high when `row_idx` is even and `row_clk_n` is high when `row_idx` is odd.
- R9: The two members of a shift-clock pair are never high in the same cycle.
- R10: If reset is asserted partway through a frame, releasing it restarts the sequence at row block 0 and column block 0, with both start pulses high.

Both block counts must be even, so that the phase of each pair keeps alternating across the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| row_start | output | 1 | High during row block 0 of each frame |
| row_clk | output | 1 | Row shift clock, strobes even row blocks |
| row_clk_n | output | 1 | Complementary row shift clock, strobes odd row blocks |
| col_start | output | 1 | High during column block 0 of each row block |
| col_clk | output | 1 | Column shift clock, strobes even column blocks |
| col_clk_n | output | 1 | Complementary column shift clock, strobes odd column blocks |
| row_idx | output | idx_width(ROW_BLOCKS) | Current row block |
| col_idx | output | idx_width(COL_BLOCKS) | Current column block |

## Verification
The bench follows the wraps at both levels. A column counter that runs one block too far, or a row counter that steps on the wrong column, shows up as an index mismatch at the boundary, or as a start pulse that lasts the wrong length. The dead windows at the start of each block are checked cycle by cycle. A pair that switches without them, or that uses the wrong index bit, drives the wrong member high, or drives both members high at once. Reset is also applied in the middle of a frame: a design that keeps stale counts after release misses the realigned start pulses.

// File: rtl/scan_pkg.sv
package scan_pkg;
  // Counter width for a modulo-n index, never less than one bit.
  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/block_counter.sv
module block_counter #(
  parameter int N = 8,
  localparam int W = scan_pkg::idx_width(N)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  output logic [W-1:0] idx,
  output logic         wrap
);
  assign wrap = adv && (idx == W'(N - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    idx <= '0;
    else if (wrap) idx <= '0;
    else if (adv)  idx <= idx + W'(1);
  end
endmodule

// File: rtl/shift_pair.sv
module shift_pair (
  input  logic enable,
  input  logic phase,
  input  logic dead,
  output logic pos,
  output logic neg
);
  logic live;
  assign live = enable && !dead;
  assign pos  = live && !phase;
  assign neg  = live && phase;
endmodule

// File: rtl/scan_timing_gen.sv
module scan_timing_gen import scan_pkg::*; #(
  parameter int ROW_BLOCKS = 90,
  parameter int COL_BLOCKS = 80,
  parameter int COL_TICKS  = 32,
  parameter int DEAD_TICKS = 2
) (
  input  logic                               clk,
  input  logic                               rst_n,
  output logic                               row_start,
  output logic                               row_clk,
  output logic                               row_clk_n,
  output logic                               col_start,
  output logic                               col_clk,
  output logic                               col_clk_n,
  output logic [idx_width(ROW_BLOCKS)-1:0]   row_idx,
  output logic [idx_width(COL_BLOCKS)-1:0]   col_idx
);
  localparam int TW = idx_width(COL_TICKS);

  logic          running;
  logic [TW-1:0] tick;
  logic          tick_wrap, col_wrap, row_wrap;
  logic          col_dead, row_dead;

  // One idle cycle after reset, then the counters run freely.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) running <= 1'b0;
    else        running <= 1'b1;
  end

  block_counter #(.N(COL_TICKS)) u_tick (
    .clk(clk), .rst_n(rst_n), .adv(running), .idx(tick), .wrap(tick_wrap));

  block_counter #(.N(COL_BLOCKS)) u_col (
    .clk(clk), .rst_n(rst_n), .adv(tick_wrap), .idx(col_idx), .wrap(col_wrap));

  block_counter #(.N(ROW_BLOCKS)) u_row (
    .clk(clk), .rst_n(rst_n), .adv(col_wrap), .idx(row_idx), .wrap(row_wrap));

  assign col_dead = tick < TW'(DEAD_TICKS);
  assign row_dead = col_dead && (col_idx == '0);

  shift_pair u_col_pair (
    .enable(running), .phase(col_idx[0]), .dead(col_dead),
    .pos(col_clk), .neg(col_clk_n));

  shift_pair u_row_pair (
    .enable(running), .phase(row_idx[0]), .dead(row_dead),
    .pos(row_clk), .neg(row_clk_n));

  assign col_start = running && (col_idx == '0);
  assign row_start = running && (row_idx == '0);

  logic unused_row_wrap;
  assign unused_row_wrap = row_wrap;
endmodule

// File: rtl/scan_timing_chk.sv
module scan_timing_chk import scan_pkg::*; #(
  parameter int ROW_BLOCKS = 90,
  parameter int COL_BLOCKS = 80,
  parameter int COL_TICKS  = 32,
  parameter int DEAD_TICKS = 2
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic                             row_start,
  input logic                             row_clk,
  input logic                             row_clk_n,
  input logic                             col_start,
  input logic                             col_clk,
  input logic                             col_clk_n,
  input logic [idx_width(ROW_BLOCKS)-1:0] row_idx,
  input logic [idx_width(COL_BLOCKS)-1:0] col_idx
);
  localparam int RW = idx_width(ROW_BLOCKS);
  localparam int CW = idx_width(COL_BLOCKS);

  initial begin
    a_r9_even_counts: assert (ROW_BLOCKS % 2 == 0 && COL_BLOCKS % 2 == 0
                              && DEAD_TICKS >= 1 && DEAD_TICKS < COL_TICKS);
  end

  a_r9_col_pair_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(col_clk && col_clk_n));

  a_r9_row_pair_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(row_clk && row_clk_n));

  a_r7_col_dead_before_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(col_clk) |-> !$past(col_clk_n));

  a_r8_row_dead_before_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(row_clk_n) |-> !$past(row_clk));

  a_r3_col_step: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(col_idx) |-> (col_idx == $past(col_idx) + CW'(1)) || (col_idx == '0));

  a_r4_row_steps_on_col_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(row_idx) |-> (col_idx == '0) && ($past(col_idx) == CW'(COL_BLOCKS - 1)));

  a_r6_row_start_inside_col_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(row_start) |-> col_start);

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |-> !row_start && !col_start && !row_clk && !col_clk && row_idx == RW'(0));
endmodule

bind scan_timing_gen scan_timing_chk #(
  .ROW_BLOCKS(ROW_BLOCKS), .COL_BLOCKS(COL_BLOCKS),
  .COL_TICKS(COL_TICKS), .DEAD_TICKS(DEAD_TICKS)
) u_chk (.*);

// File: tb/scan_timing_gen_bench.sv
module scan_timing_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int RB = 4;
  localparam int CB = 6;
  localparam int CT = 5;
  localparam int DT = 1;
  localparam int FRAME = RB * CB * CT;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic row_start, row_clk, row_clk_n, col_start, col_clk, col_clk_n;
  logic [1:0] row_idx;
  logic [2:0] col_idx;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  scan_timing_gen #(.ROW_BLOCKS(RB), .COL_BLOCKS(CB), .COL_TICKS(CT), .DEAD_TICKS(DT))
    u_scan_timing_gen (
      .clk(clk), .rst_n(rst_n),
      .row_start(row_start), .row_clk(row_clk), .row_clk_n(row_clk_n),
      .col_start(col_start), .col_clk(col_clk), .col_clk_n(col_clk_n),
      .row_idx(row_idx), .col_idx(col_idx));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Compare every output against the model for cycle k since release.
  task automatic check_cycle(input int k);
    int t = k % CT;
    int c = (k / CT) % CB;
    int r = (k / (CT * CB)) % RB;
    bit cdead = (t < DT);
    bit rdead = cdead && (c == 0);
    chk("R3 col_idx", int'(col_idx), c);
    chk("R4 row_idx", int'(row_idx), r);
    chk("R5 col_start", int'(col_start), int'(c == 0));
    chk("R6 row_start", int'(row_start), int'(r == 0));
    chk("R7 col_clk", int'(col_clk), int'(!cdead && (c % 2 == 0)));
    chk("R7 col_clk_n", int'(col_clk_n), int'(!cdead && (c % 2 == 1)));
    chk("R8 row_clk", int'(row_clk), int'(!rdead && (r % 2 == 0)));
    chk("R8 row_clk_n", int'(row_clk_n), int'(!rdead && (r % 2 == 1)));
    chk("R9 pairs exclusive", int'((col_clk && col_clk_n) || (row_clk && row_clk_n)), 0);
  endtask

  task automatic release_reset();
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic test_reset_state();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 starts low", int'(row_start | col_start), 0);
    chk("R1 clocks low", int'(row_clk | row_clk_n | col_clk | col_clk_n), 0);
    chk("R1 indices zero", int'(row_idx) + int'(col_idx), 0);
  endtask

  task automatic test_first_cycle();
    release_reset();
    chk("R2 row_start", int'(row_start), 1);
    chk("R2 col_start", int'(col_start), 1);
    chk("R2 indices", int'(row_idx) + int'(col_idx), 0);
  endtask

  task automatic test_full_frames();
    for (int k = 0; k < 2 * FRAME + 12; k++) begin
      check_cycle(k);
      @(negedge clk);
    end
  endtask

  task automatic test_midframe_reset();
    repeat (FRAME / 2 + 7) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R10 cleared in reset", int'(row_idx) + int'(col_idx), 0);
    release_reset();
    chk("R10 row_start realigned", int'(row_start), 1);
    chk("R10 col_start realigned", int'(col_start), 1);
    for (int k = 0; k < CB * CT + 8; k++) begin
      check_cycle(k);
      @(negedge clk);
    end
  endtask

  initial begin
    test_reset_state();
    test_first_cycle();
    test_full_frames();
    test_midframe_reset();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule